// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block sequences the timing of a single flash program or erase operation. A bank of six byte-wide reload registers sets how long each phase lasts. A start command with an operation code starts the sequence, which runs idle, transition, pulse, end delay and back to idle. While a sequence runs the block holds a busy flag and drives a high-voltage pulse enable only during the pulse phase. When the end delay expires it raises a one-cycle done strobe.

All counting is measured in prescaler ticks. A tick is a single-cycle enable produced outside the block, and the counters stand still in every cycle where it is low. Each phase multiplies its reload value plus one by its own scale: one, eight or 4096. The reload registers are frozen while busy, so a bus write cannot disturb a sequence that is already running.

Top module: `flash_pe_timer`

## Requirements
- R1: Six reload registers of 8 bits are selected by `addr`: 0 transition, 1 program, 2 page erase, 3 module erase, 4 end delay, 5 module erase end delay. A write with `wr_en` at an idle cycle updates the selected register at the next clock edge. `rd_data` shows the register at `addr` combinationally. Addresses 6 and 7 read as zero, and writes to them are dropped.
- R2: After reset the registers read 30h, 16h, 04h, EAh, 18h and 3Ch for addresses 0 to 5. After reset `busy`, `hv_en` and `done` are low.
- R3: The transition phase comes first after an accepted start. It lasts (transition reload + 1) ticks, with `busy` high and `hv_en` low.
- R4: The pulse phase follows the transition phase, and `hv_en` is high only in this phase. It lasts 8×(program reload+1) ticks for op code 0, 4096×(page erase reload+1) ticks for op code 1, and 4096×(module erase reload+1) ticks for op code 2.
- R5: The end delay phase follows the pulse phase with `hv_en` low. It lasts (end reload+1) ticks after op codes 0 and 1, and 8×(module erase end reload+1) ticks after op code 2.
- R6: The phase counters advance only in cycles where `tick` is high. A cycle with `tick` low changes neither the phase nor `busy`.
- R7: A register write made while `busy` is high, or in the same cycle as an accepted start, is ignored, and the register keeps its old value.
- R8: `start` is accepted only when `busy` is low and `op` is 0, 1 or 2. A start raised while busy, or with op code 3, has no effect.
- R9: In the cycle after the end delay expires, `done` is high for exactly one cycle and `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler tick enable |
| start | input | 1 | Start a sequence |
| op | input | 2 | Operation code: 0 program, 1 page erase, 2 module erase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the register at `addr` |
| busy | output | 1 | Sequence in progress |
| hv_en | output | 1 | High-voltage pulse enable |
| done | output | 1 | One-cycle completion strobe |

## Verification
`busy` rises at the first clock edge after a start is sampled. Each phase then ends on the clock edge that consumes its last tick, and `done` follows one edge after the end delay expires. For that reason the bench does not predict absolute cycle numbers. It sets `tick` just after each falling edge and samples the outputs one time step later. It then counts, for each phase, the cycles in which that phase was active and `tick` was high, and compares each count with the reload-based formula. This also works for the sparse tick pattern. Register read data is combinational and is compared in the same half cycle as `addr` is set, and a write is checked one edge later.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    localparam int NUM_REGS = 6;
    localparam int ADDR_W   = 3;

    // register slots; the sequencer selects by these indices
    localparam int IX_TRAN = 0;
    localparam int IX_PROG = 1;
    localparam int IX_PAGE = 2;
    localparam int IX_MOD  = 3;
    localparam int IX_END  = 4;
    localparam int IX_MEND = 5;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_PAGE    = 2'd1,
        OP_MODULE  = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRAN  = 2'd1,
        PH_PULSE = 2'd2,
        PH_END   = 2'd3
    } phase_e;

    function automatic logic [7:0] reset_byte(input int idx);
        logic [7:0] v;
        case (idx)
            IX_TRAN: v = 8'h30;
            IX_PROG: v = 8'h16;
            IX_PAGE: v = 8'h04;
            IX_MOD:  v = 8'hEA;
            IX_END:  v = 8'h18;
            IX_MEND: v = 8'h3C;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/fpt_regbank.sv
module fpt_regbank
    import fpt_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int NREG  = NUM_REGS,
    parameter int AW    = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       lock,
    output logic [NREG-1:0][REG_W-1:0] regs,
    output logic [REG_W-1:0]           rd_data
);

    logic wr_ok;
    assign wr_ok = wr_en && !lock;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic sel;
        assign sel = (addr == AW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= REG_W'(reset_byte(i));
            end else if (wr_ok && sel) begin
                regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/fpt_phase_cnt.sv
module fpt_phase_cnt #(
    parameter int REG_W = 8,
    parameter int CNT_W = 20,
    parameter int SH_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] reload,
    input  logic [SH_W-1:0]  shift,
    input  logic             tick,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   base;
    logic [CNT_W:0]   scaled;
    logic [CNT_W-1:0] len_m1;

    // phase length in ticks is (reload+1) << shift; hold length-1
    always_comb begin
        base   = (CNT_W+1)'(reload) + (CNT_W+1)'(1);
        scaled = base << shift;
        len_m1 = CNT_W'(scaled - (CNT_W+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_m1;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/fpt_seq.sv
module fpt_seq
    import fpt_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int NREG        = NUM_REGS,
    parameter int SH_W        = 5,
    parameter int PROG_SHIFT  = 3,
    parameter int ERASE_SHIFT = 12,
    parameter int MEND_SHIFT  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       start,
    input  logic [1:0]                 op,
    input  logic [NREG-1:0][REG_W-1:0] regs,
    input  logic                       zero,
    output logic                       load,
    output logic [REG_W-1:0]           ld_reload,
    output logic [SH_W-1:0]            ld_shift,
    output logic                       start_acc,
    output logic                       busy,
    output logic                       hv_en,
    output logic                       done
);

    phase_e phase_q, phase_d;
    op_e    op_q;
    logic   expire;
    logic   done_d;

    assign busy      = (phase_q != PH_IDLE);
    assign hv_en     = (phase_q == PH_PULSE);
    assign start_acc = start && !busy && (op_e'(op) != OP_NONE);
    assign expire    = busy && tick && zero;

    always_comb begin
        phase_d   = phase_q;
        load      = 1'b0;
        ld_reload = regs[IX_TRAN];
        ld_shift  = '0;
        done_d    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_acc) begin
                    phase_d   = PH_TRAN;
                    load      = 1'b1;
                    ld_reload = regs[IX_TRAN];
                    ld_shift  = '0;
                end
            end
            PH_TRAN: begin
                if (expire) begin
                    phase_d = PH_PULSE;
                    load    = 1'b1;
                    case (op_q)
                        OP_PAGE: begin
                            ld_reload = regs[IX_PAGE];
                            ld_shift  = SH_W'(ERASE_SHIFT);
                        end
                        OP_MODULE: begin
                            ld_reload = regs[IX_MOD];
                            ld_shift  = SH_W'(ERASE_SHIFT);
                        end
                        default: begin
                            ld_reload = regs[IX_PROG];
                            ld_shift  = SH_W'(PROG_SHIFT);
                        end
                    endcase
                end
            end
            PH_PULSE: begin
                if (expire) begin
                    phase_d = PH_END;
                    load    = 1'b1;
                    if (op_q == OP_MODULE) begin
                        ld_reload = regs[IX_MEND];
                        ld_shift  = SH_W'(MEND_SHIFT);
                    end else begin
                        ld_reload = regs[IX_END];
                        ld_shift  = '0;
                    end
                end
            end
            PH_END: begin
                if (expire) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_PROGRAM;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= done_d;
            if (start_acc) op_q <= op_e'(op);
        end
    end

endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer
    import fpt_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int PROG_SHIFT  = 3,
    parameter int ERASE_SHIFT = 12,
    parameter int MEND_SHIFT  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             hv_en,
    output logic             done
);

    localparam int MAX_SH = max3(PROG_SHIFT, ERASE_SHIFT, MEND_SHIFT);
    localparam int CNT_W  = REG_W + MAX_SH;
    localparam int SH_W   = $clog2(MAX_SH + 1) + 1;

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [NUM_REGS*REG_W-1:0]      regs_flat;
    logic                           load;
    logic [REG_W-1:0]               ld_reload;
    logic [SH_W-1:0]                ld_shift;
    logic                           zero;
    logic                           start_acc;
    logic                           lock;

    assign regs_flat = regs;
    assign lock      = busy || start_acc;

    fpt_regbank #(
        .REG_W (REG_W),
        .NREG  (NUM_REGS),
        .AW    (3)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .lock    (lock),
        .regs    (regs),
        .rd_data (rd_data)
    );

    fpt_seq #(
        .REG_W       (REG_W),
        .NREG        (NUM_REGS),
        .SH_W        (SH_W),
        .PROG_SHIFT  (PROG_SHIFT),
        .ERASE_SHIFT (ERASE_SHIFT),
        .MEND_SHIFT  (MEND_SHIFT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .op        (op),
        .regs      (regs),
        .zero      (zero),
        .load      (load),
        .ld_reload (ld_reload),
        .ld_shift  (ld_shift),
        .start_acc (start_acc),
        .busy      (busy),
        .hv_en     (hv_en),
        .done      (done)
    );

    fpt_phase_cnt #(
        .REG_W (REG_W),
        .CNT_W (CNT_W),
        .SH_W  (SH_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .reload (ld_reload),
        .shift  (ld_shift),
        .tick   (tick),
        .zero   (zero)
    );

endmodule

// File: rtl/fpt_chk.sv
module fpt_chk #(
    parameter int REG_W = 8,
    parameter int NREG  = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  start,
    input logic                  busy,
    input logic                  hv_en,
    input logic                  done,
    input logic [NREG*REG_W-1:0] regs_flat
);

    assert_hv_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
        hv_en |-> busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fall_gives_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> (busy && $stable(hv_en)));

    assert_regs_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(regs_flat));

    assert_rise_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind flash_pe_timer fpt_chk #(
    .REG_W (REG_W),
    .NREG  (fpt_pkg::NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .busy      (busy),
    .hv_en     (hv_en),
    .done      (done),
    .regs_flat (regs_flat)
);

// File: tb/sim_flash_pe_timer.sv
module sim_flash_pe_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       busy, hv_en, done;

    int total = 0;
    int bad   = 0;
    int shadow [6] = '{8'h30, 8'h16, 8'h04, 8'hEA, 8'h18, 8'h3C};

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .op(op),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .hv_en(hv_en), .done(done)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 6) shadow[a] = d;
    endtask

    task automatic read_chk(input int a, input int exp, input string req);
        @(negedge clk);
        addr = 3'(a);
        #1;
        chk(int'(rd_data), exp, req, $sformatf("read addr %0d", a));
    endtask

    // inj: 0 none, 1 write while busy, 2 start while busy, 3 write with start
    task automatic run_op(input int opc, input int period, input int inj, input string req);
        int  t_exp, p_exp, e_exp;
        int  tt = 0, pt = 0, et = 0, dn = 0, cyc = 0;
        bit  seen_hv = 1'b0, fin = 1'b0;
        t_exp = shadow[0] + 1;
        if (opc == 0)      p_exp = 8 * (shadow[1] + 1);
        else if (opc == 1) p_exp = 4096 * (shadow[2] + 1);
        else               p_exp = 4096 * (shadow[3] + 1);
        e_exp = (opc == 2) ? 8 * (shadow[5] + 1) : shadow[4] + 1;
        @(negedge clk);
        start = 1'b1; op = 2'(opc); tick = 1'b1;
        if (inj == 3) begin wr_en = 1'b1; addr = 3'd1; wr_data = 8'h77; end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        #1;
        chk(int'(busy), 1, "R8", {req, " busy after start"});
        while (!fin) begin
            tick = ((cyc % period) == 0);
            cyc++;
            if (inj == 1 && cyc == 5) begin wr_en = 1'b1; addr = 3'd1; wr_data = 8'hAA; end
            if (inj == 2 && cyc == 7) begin start = 1'b1; op = 2'd2; end
            #1;
            if (done) begin
                dn++;
                chk(int'(busy), 0, "R9", {req, " busy low with done"});
                fin = 1'b1;
            end else if (busy && tick) begin
                if (hv_en) begin pt++; seen_hv = 1'b1; end
                else if (seen_hv) et++;
                else tt++;
            end
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        tick = 1'b1;
        #1;
        chk(int'(done), 0, "R9", {req, " done one cycle"});
        chk(int'(busy), 0, "R9", {req, " idle after done"});
        chk(tt, t_exp, "R3", {req, " transition ticks"});
        chk(pt, p_exp, "R4", {req, " pulse ticks"});
        chk(et, e_exp, "R5", {req, " end ticks"});
        chk(dn, 1, "R9", {req, " done count"});
    endtask

    task automatic t_reset;
        #1;
        chk(int'(busy), 0, "R2", "busy at reset");
        chk(int'(hv_en), 0, "R2", "hv_en at reset");
        chk(int'(done), 0, "R2", "done at reset");
        for (int i = 0; i < 6; i++) read_chk(i, shadow[i], "R2");
    endtask

    task automatic t_spare_addr;
        write_reg(6, 8'h5A);
        write_reg(7, 8'hC3);
        read_chk(6, 0, "R1");
        read_chk(7, 0, "R1");
        write_reg(0, 2);
        write_reg(1, 1);
        write_reg(2, 0);
        write_reg(3, 0);
        write_reg(4, 3);
        write_reg(5, 1);
        for (int i = 0; i < 6; i++) read_chk(i, shadow[i], "R1");
    endtask

    task automatic t_default_program;
        run_op(0, 1, 0, "R4 default program");
    endtask

    task automatic t_program;  run_op(0, 1, 0, "R4 program");     endtask
    task automatic t_page;     run_op(1, 1, 0, "R4 page erase");  endtask
    task automatic t_module;   run_op(2, 1, 0, "R5 module erase"); endtask
    task automatic t_sparse;   run_op(0, 3, 0, "R6 sparse tick"); endtask

    task automatic t_stall;
        int hold = 0;
        @(negedge clk);
        start = 1'b1; op = 2'd0; tick = 1'b1;
        @(negedge clk);
        start = 1'b0; tick = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #1;
            if (busy && !hv_en) hold++;
        end
        chk(hold, 40, "R6", "frozen without tick");
        tick = 1'b1;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_write_busy;
        run_op(0, 1, 1, "R7 write while busy");
        read_chk(1, shadow[1], "R7");
    endtask

    task automatic t_write_with_start;
        run_op(0, 1, 3, "R7 write with start");
        read_chk(1, shadow[1], "R7");
    endtask

    task automatic t_start_busy;
        run_op(0, 1, 2, "R8 start while busy");
    endtask

    task automatic t_bad_op;
        int seen = 0;
        @(negedge clk);
        start = 1'b1; op = 2'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (busy || hv_en || done) seen++;
            @(negedge clk);
        end
        chk(seen, 0, "R8", "op code 3 ignored");
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        bad++; total++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_program();
        t_spare_addr();
        t_program();
        t_page();
        t_module();
        t_sparse();
        t_stall();
        t_write_busy();
        t_write_with_start();
        t_start_busy();
        t_bad_op();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule